// File: doc/BRIEF.md
# Multi-channel TDC hit derandomizer

This block is the readout stage behind a 16-channel time-to-digital converter. Any channel that raises its hit strobe has its 5-bit fine interpolator code captured together with the value of a shared 48-bit free-running coarse counter. All channels that fire in the same clock cycle form one capture group, and they share the coarse value sampled on that edge. The group is taken apart one channel per two cycles, lowest channel first. Each hit becomes a record in a derandomizing FIFO of 16 or 32 entries.

A serializer takes records out of the FIFO and sends each one as four 16-bit words on consecutive cycles, with a valid strobe. It does this without any request from downstream, and records with no gap between them go out back to back. Hits that cannot be stored are dropped and raise a sticky loss flag. A run-end pulse freezes capture so that the pipeline drains, and a done flag then reports when everything has left the block.

Top module: `tdc_derand`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `lost_flag` and `done` are 0.
- R2: Each record is sent as four words. Word 0 carries the channel number in bits [15:12], zeros in bits [11:5] and the fine code in bits [4:0]. Words 1, 2 and 3 carry coarse bits [47:32], [31:16] and [15:0], in that order.
- R3: When a hit reaches an idle, empty block, `out_valid` rises two clock edges after the edge that samples the strobe. Word 0 is visible in the cycle after that second edge.
- R4: Channels that fire in the same cycle are sent in ascending channel order. Their records follow one another with no idle output cycle between them.
- R5: Output is pushed without a request. `out_valid` stays high for a whole number of four-word records and never for part of one.
- R6: A strobe seen while an earlier capture group still has channels left to store is dropped, and `lost_flag` is set.
- R7: A record offered to the FIFO while the FIFO holds DEPTH entries at the start of that cycle is dropped. `lost_flag` then goes to 1 and stays at 1 until reset.
- R8: The FIFO holds DEPTH records (parameter, 16 or 32). With DEPTH=16, four full 16-channel groups captured 35 cycles apart deliver exactly 50 records.
- R9: After a `run_end` pulse, new strobes are ignored and do not set `lost_flag`. `done` rises once no capture, FIFO entry or partly sent record remains, and it then stays high with `out_valid` low.
- R10: Every record carries the coarse value present on the edge that captured its strobe. Fine code i is taken from `hit_fine` bits [5i+4:5i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_strobe | input | 16 | One strobe bit per channel |
| hit_fine | input | 80 | Fine codes, 5 bits per channel, channel 0 in the low bits |
| coarse_time | input | 48 | Shared free-running coarse counter |
| run_end | input | 1 | Pulse that ends the run and starts draining |
| out_word | output | 16 | Output data word |
| out_valid | output | 1 | Output word is valid |
| lost_flag | output | 1 | Sticky flag for dropped hits |
| done | output | 1 | Run ended and the block is empty |

## Verification
A wrong group mask or scan phase shows up within two cycles as a shifted `out_valid` rise, or as a record for the wrong channel in word 0. A miscounted FIFO level shows up as a wrong number of records during an overload burst, or as `lost_flag` rising too early or too late. The four-word count and the `done` flag show any record that is left partly sent. The bench model is compared with the ports on every cycle, so a divergence is reported in the cycle where it first reaches an output.

// File: rtl/tdc_derand_pkg.sv
package tdc_derand_pkg;

    localparam int NCH        = 16;
    localparam int FINE_W     = 5;
    localparam int COARSE_W   = 48;
    localparam int WORD_W     = 16;
    localparam int CH_W       = $clog2(NCH);

    typedef struct packed {
        logic [CH_W-1:0]     chan;
        logic [FINE_W-1:0]   fine;
        logic [COARSE_W-1:0] coarse;
    } hit_rec_t;

    typedef enum logic [1:0] {
        W_HEAD = 2'd0,
        W_CHI  = 2'd1,
        W_CMID = 2'd2,
        W_CLO  = 2'd3
    } word_sel_t;

    // Index of the lowest set bit; 0 when the mask is empty.
    function automatic logic [CH_W-1:0] lowest_chan(input logic [NCH-1:0] m);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input hit_rec_t r, input word_sel_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        case (s)
            W_HEAD: begin
                w[WORD_W-1 -: CH_W] = r.chan;
                w[FINE_W-1:0]       = r.fine;
            end
            W_CHI:   w = r.coarse[COARSE_W-1 -: WORD_W];
            W_CMID:  w = r.coarse[COARSE_W-WORD_W-1 -: WORD_W];
            default: w = r.coarse[WORD_W-1:0];
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tdc_capture.sv
module tdc_capture
    import tdc_derand_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        strobe,
    input  logic [NCH*FINE_W-1:0] fine_bus,
    input  logic [COARSE_W-1:0]   coarse,
    input  logic                  flush,
    input  logic                  fifo_full,
    output logic                  wr_en,
    output hit_rec_t              wr_rec,
    output logic                  drop,
    output logic                  idle
);

    logic [NCH-1:0]      mask_q;
    logic [FINE_W-1:0]   fine_q [NCH];
    logic [COARSE_W-1:0] coarse_q;
    logic                phase_q;
    logic [CH_W-1:0]     lo;
    logic                want;
    logic                load;

    always_comb begin
        idle          = (mask_q == '0);
        load          = idle && !flush && (strobe != '0);
        lo            = lowest_chan(mask_q);
        want          = !idle && phase_q;
        wr_en         = want && !fifo_full;
        wr_rec.chan   = lo;
        wr_rec.fine   = fine_q[lo];
        wr_rec.coarse = coarse_q;
        drop          = (want && fifo_full) || (!flush && !idle && (strobe != '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            coarse_q <= '0;
            phase_q  <= 1'b0;
        end else if (load) begin
            mask_q   <= strobe;
            coarse_q <= coarse;
            phase_q  <= 1'b1;
        end else if (!idle) begin
            if (phase_q) begin
                mask_q[lo] <= 1'b0;
                phase_q    <= 1'b0;
            end else begin
                phase_q    <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_fine
        always_ff @(posedge clk) begin
            if (rst)       fine_q[i] <= '0;
            else if (load) fine_q[i] <= fine_bus[i*FINE_W +: FINE_W];
        end
    end

endmodule

// File: rtl/tdc_fifo.sv
module tdc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic                     rd_en,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     full,
    output logic                     empty
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign rd_data = mem[rd_ptr];
    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            level <= level + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

endmodule

// File: rtl/tdc_serializer.sv
module tdc_serializer
    import tdc_derand_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  hit_rec_t          head,
    output logic              pop,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid
);

    logic      busy_q;
    word_sel_t sel_q;
    hit_rec_t  cur_q;

    assign pop       = !fifo_empty && (!busy_q || sel_q == W_CLO);
    assign out_word  = pack_word(cur_q, sel_q);
    assign out_valid = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sel_q  <= W_HEAD;
            cur_q  <= '0;
        end else if (pop) begin
            busy_q <= 1'b1;
            sel_q  <= W_HEAD;
            cur_q  <= head;
        end else if (busy_q && sel_q != W_CLO) begin
            sel_q  <= word_sel_t'(sel_q + 2'd1);
        end else if (busy_q) begin
            busy_q <= 1'b0;
            sel_q  <= W_HEAD;
        end
    end

endmodule

// File: rtl/tdc_derand.sv
module tdc_derand
    import tdc_derand_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        hit_strobe,
    input  logic [NCH*FINE_W-1:0] hit_fine,
    input  logic [COARSE_W-1:0]   coarse_time,
    input  logic                  run_end,
    output logic [WORD_W-1:0]     out_word,
    output logic                  out_valid,
    output logic                  lost_flag,
    output logic                  done
);

    localparam int REC_W = $bits(hit_rec_t);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic             flushing_q;
    logic             wr_en, drop, grp_idle;
    hit_rec_t         wr_rec, head;
    logic [REC_W-1:0] rd_raw;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full, fifo_empty, pop;

    tdc_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .strobe    (hit_strobe),
        .fine_bus  (hit_fine),
        .coarse    (coarse_time),
        .flush     (flushing_q),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_rec    (wr_rec),
        .drop      (drop),
        .idle      (grp_idle)
    );

    tdc_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_rec),
        .rd_en   (pop),
        .rd_data (rd_raw),
        .level   (fifo_level),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    assign head = hit_rec_t'(rd_raw);

    tdc_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .head       (head),
        .pop        (pop),
        .out_word   (out_word),
        .out_valid  (out_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flushing_q <= 1'b0;
            lost_flag  <= 1'b0;
        end else begin
            if (run_end) flushing_q <= 1'b1;
            if (drop)    lost_flag  <= 1'b1;
        end
    end

    assign done = flushing_q && grp_idle && fifo_empty && !out_valid;

endmodule

// File: rtl/tdc_derand_chk.sv
module tdc_derand_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      out_word,
    input logic             out_valid,
    input logic             lost_flag,
    input logic             done,
    input logic [LVL_W-1:0] fifo_level
);

    logic [1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)            pos_q <= 2'd0;
        else if (out_valid) pos_q <= pos_q + 2'd1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !lost_flag && !done));

    assert_head_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos_q == 2'd0) |-> (out_word[11:5] == 7'd0));

    assert_whole_records_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (pos_q == 2'd0));

    assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        lost_flag |=> lost_flag);

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

bind tdc_derand tdc_derand_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_word   (out_word),
    .out_valid  (out_valid),
    .lost_flag  (lost_flag),
    .done       (done),
    .fifo_level (fifo_level)
);

// File: tb/sim_tdc_derand.sv
`timescale 1ns/1ps
module sim_tdc_derand;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] strobe;
    logic [79:0] fine_bus;
    logic [47:0] coarse;
    logic        run_end;
    logic [15:0] out_word;
    logic        out_valid, lost_flag, done;

    always #2 clk = ~clk;

    tdc_derand #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .hit_strobe(strobe), .hit_fine(fine_bus),
        .coarse_time(coarse), .run_end(run_end), .out_word(out_word),
        .out_valid(out_valid), .lost_flag(lost_flag), .done(done)
    );

    initial coarse = 48'hA5C3_0000_0F00;
    always @(negedge clk) coarse <= coarse + 48'd1;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit [15:0]   m_mask;
    int          m_fine [16];
    logic [47:0] m_coarse;
    bit          m_phase, m_busy, m_lost, m_flush;
    int          m_idx, c_ch, c_fn, m_accepted, pre_size, lo;
    logic [47:0] c_co;
    int          q_ch[$], q_fn[$];
    logic [47:0] q_co[$];
    bit          do_pop, do_wr;

    function automatic logic [15:0] exp_word(int idx, int ch, int fn, logic [47:0] co);
        case (idx)
            0:       return {ch[3:0], 7'b0, fn[4:0]};
            1:       return co[47:32];
            2:       return co[31:16];
            default: return co[15:0];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask = 0; m_phase = 0; m_busy = 0; m_lost = 0; m_flush = 0; m_idx = 0;
            q_ch.delete(); q_fn.delete(); q_co.delete(); m_accepted = 0;
        end else begin
            pre_size = q_ch.size();
            do_pop = (!m_busy || m_idx == 3) && pre_size > 0;
            do_wr  = (m_mask != 0) && m_phase;
            lo = 0;
            for (int i = 15; i >= 0; i--) if (m_mask[i]) lo = i;
            if (do_pop) begin
                c_ch = q_ch.pop_front(); c_fn = q_fn.pop_front(); c_co = q_co.pop_front();
                m_busy = 1; m_idx = 0;
            end else if (m_busy && m_idx < 3) m_idx++;
            else if (m_busy) m_busy = 0;
            if (do_wr) begin
                if (pre_size == DEPTH) m_lost = 1;
                else begin
                    q_ch.push_back(lo); q_fn.push_back(m_fine[lo]); q_co.push_back(m_coarse);
                    m_accepted++;
                end
            end
            if (m_mask == 0) begin
                if (!m_flush && strobe != 0) begin
                    m_mask = strobe; m_phase = 1; m_coarse = coarse;
                    for (int i = 0; i < 16; i++) m_fine[i] = int'(fine_bus[i*5 +: 5]);
                end
            end else begin
                if (!m_flush && strobe != 0) m_lost = 1;
                if (m_phase) begin m_mask[lo] = 0; m_phase = 0; end
                else m_phase = 1;
            end
            if (run_end) m_flush = 1;
        end
    end

    // Port monitor and per-cycle comparison
    int ev = 0, dut_pos = 0, cur_run = 0, last_run = 0;
    int obs_ch[$];
    bit exp_done;

    always @(negedge clk) begin
        if (cmp_en) begin
            exp_done = m_flush && m_mask == 0 && q_ch.size() == 0 && !m_busy;
            chk(out_valid == m_busy, "R5 out_valid", 64'(out_valid), 64'(m_busy));
            if (out_valid && m_busy)
                chk(out_word == exp_word(m_idx, c_ch, c_fn, c_co), "R2 out_word",
                    64'(out_word), 64'(exp_word(m_idx, c_ch, c_fn, c_co)));
            chk(lost_flag == m_lost, "R7 lost_flag", 64'(lost_flag), 64'(m_lost));
            chk(done == exp_done, "R9 done", 64'(done), 64'(exp_done));
        end
        if (rst) begin
            dut_pos = 0; cur_run = 0;
        end else if (out_valid) begin
            if (dut_pos == 0) begin obs_ch.push_back(int'(out_word[15:12])); ev++; end
            dut_pos = (dut_pos + 1) % 4;
            cur_run++;
        end else if (cur_run != 0) begin
            last_run = cur_run; cur_run = 0;
        end
    end

    task automatic do_reset();
        @(negedge clk); #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        obs_ch.delete(); ev = 0; last_run = 0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); #1 strobe = m;
        @(negedge clk); #1 strobe = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    logic [47:0] cap;

    initial begin
        strobe = '0; fine_bus = '0; run_end = 1'b0; rst = 1'b1;
        do_reset();
        cmp_en = 1'b1;
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
        chk(lost_flag == 0, "R1 lost_flag", 64'(lost_flag), 0);
        chk(done == 0, "R1 done", 64'(done), 0);

        // R3, R2, R10: single hit latency and record layout
        idle(2);
        @(negedge clk); #1 strobe = 16'h0020; fine_bus[25 +: 5] = 5'd17; cap = coarse;
        @(negedge clk); #1 strobe = '0;
        @(negedge clk); #1 chk(out_valid == 0, "R3 early valid", 64'(out_valid), 0);
        @(negedge clk); #1 chk(out_valid == 1, "R3 valid after two edges", 64'(out_valid), 1);
        chk(out_word == {4'd5, 7'd0, 5'd17}, "R2 head word", 64'(out_word), 64'({4'd5, 7'd0, 5'd17}));
        @(negedge clk); #1 chk(out_word == cap[47:32], "R10 coarse high", 64'(out_word), 64'(cap[47:32]));
        @(negedge clk); #1 chk(out_word == cap[31:16], "R2 coarse mid", 64'(out_word), 64'(cap[31:16]));
        @(negedge clk); #1 chk(out_word == cap[15:0], "R10 coarse low", 64'(out_word), 64'(cap[15:0]));

        // R4: simultaneous channels, ascending and back to back
        idle(10);
        obs_ch.delete(); ev = 0;
        fine_bus = {16{5'd9}};
        pulse(16'h4204);
        idle(40);
        chk(ev == 3, "R4 record count", 64'(ev), 3);
        if (ev == 3) begin
            chk(obs_ch[0] == 2, "R4 first channel", 64'(obs_ch[0]), 2);
            chk(obs_ch[1] == 9, "R4 second channel", 64'(obs_ch[1]), 9);
            chk(obs_ch[2] == 14, "R4 third channel", 64'(obs_ch[2]), 14);
        end
        chk(last_run == 12, "R4 contiguous valid run", 64'(last_run), 12);

        // R6: strobe while a group is still being stored
        do_reset();
        @(negedge clk); #1 strobe = 16'h0001;
        @(negedge clk); #1 strobe = 16'h0002;
        @(negedge clk); #1 strobe = '0;
        chk(lost_flag == 1, "R6 lost after busy strobe", 64'(lost_flag), 1);
        idle(20);
        chk(ev == 1, "R6 only one record", 64'(ev), 1);
        if (ev > 0) chk(obs_ch[0] == 0, "R6 surviving channel", 64'(obs_ch[0]), 0);

        // R7, R8: overload with full groups
        do_reset();
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < 16; i++) fine_bus[i*5 +: 5] = 5'((i + g) % 32);
            pulse(16'hFFFF);
            if (g == 1) chk(lost_flag == 0, "R7 no loss before full", 64'(lost_flag), 0);
            idle(33);
        end
        idle(400);
        chk(lost_flag == 1, "R7 sticky loss after overflow", 64'(lost_flag), 1);
        chk(ev == 50, "R8 records delivered with depth 16", 64'(ev), 50);
        chk(ev == m_accepted, "R8 records match stored", 64'(ev), 64'(m_accepted));

        // R9: run end drains and ignores later hits
        do_reset();
        pulse(16'h0008);
        run_end = 1'b1;
        @(negedge clk); #1 run_end = 1'b0;
        chk(done == 0, "R9 not done while sending", 64'(done), 0);
        idle(2);
        pulse(16'h0080);
        idle(20);
        chk(done == 1, "R9 done after drain", 64'(done), 1);
        chk(ev == 1, "R9 later hit ignored", 64'(ev), 1);
        chk(lost_flag == 0, "R9 ignored hit not lost", 64'(lost_flag), 0);

        finish_run();
    end

endmodule